// File: doc/BRIEF.md
# Warp Barrier Unit

This block holds the warps of one thread block at a barrier until every resident warp has either reached that barrier or finished. Counting is per warp. Each serialized divergent path of a warp reports its barrier instruction as a separate one-cycle arrival pulse. Lanes of one warp never wait for the other lanes of that warp. Successive arrivals of a warp therefore pair with successive barrier instances of the other warps.

A warp that has finished pulses its exit line. From then on it counts as present at the current barrier and at every later one, until its slot leaves the resident mask. There is no timeout: a resident warp that neither arrives nor exits keeps the others stalled for as long as that lasts.

Once the last missing warp is accounted for, the release follows a fixed number of cycles later, set by the parameter `REL_DELAY` (default 20). This models the latency of one warp issuing barriers back to back. No data streams through the block, so it has no valid/ready handshake and gives no back-pressure rules. Every pin is a plain control or status level, or a one-cycle pulse.

Top module: `warp_barrier`

## Requirements
- R1: While reset is held, and in the first cycle after it, `warp_stall_o` is all zeros and `bar_done_o` is 0.
- R2: An arrival pulse on bit i from a resident warp that has not exited sets `warp_stall_o[i]` from the next cycle on. The bit stays set until the release.
- R3: The completing event is sampled at clock edge t. Every resident warp is then either arrived or exited, and at least one has arrived. After edge t+REL_DELAY, `bar_done_o` is 1 for exactly one cycle and all of `warp_stall_o` is 0 in that same cycle. Before that edge, no stall bit drops.
- R4: A further arrival pulse from a warp that is already stalled has no effect. It does not count toward the following barrier instance.
- R5: After a release, a new arrival from a warp counts toward the next barrier instance. Divergent paths of one warp thus pair with successive barriers of the other warps.
- R6: An exit pulse from a resident warp marks it as present for the pending barrier and for all later ones. An exit can itself be the completing event. The mark clears only when the warp's bit in `warp_resident_i` goes to 0.
- R7: Warps whose bit in `warp_resident_i` is 0 are not waited for. Their arrival pulses never set a stall bit.
- R8: If a resident warp neither arrives nor exits, no release occurs and the stall bits of the waiting warps stay set, however long that lasts.
- R9: If every resident warp has exited and none has arrived, `bar_done_o` never pulses.
- R10: A single resident warp that arrives again in the first cycle after each release is released REL_DELAY cycles after each arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_resident_i | input | NUM_WARPS | Level: bit i is 1 when warp slot i belongs to the block |
| warp_arrive_i | input | NUM_WARPS | One-cycle pulse per warp path that executes the barrier |
| warp_exit_i | input | NUM_WARPS | One-cycle pulse when a warp terminates |
| warp_stall_o | output | NUM_WARPS | Bit i high while warp i waits at the barrier |
| bar_done_o | output | 1 | One-cycle pulse in the cycle the barrier releases |

## Verification
A wrong arrived or exited mask shows up at the ports within one release window of REL_DELAY cycles. Either a stall bit is missing or stuck the cycle after an arrival, or `bar_done_o` pulses although a resident warp is still outstanding. A lost exit mark shows up at the next barrier instance as a release that never comes. A miscount in the release timer moves `bar_done_o` and the drop of the stall bits off their exact cycle, so every completed barrier in the bench exposes it.

// File: rtl/warp_barrier_pkg.sv
package warp_barrier_pkg;
  typedef enum logic {
    BAR_OPEN = 1'b0,
    BAR_HOLD = 1'b1
  } bar_state_e;
endpackage

// File: rtl/warp_flag_bank.sv
module warp_flag_bank #(
  parameter int NUM_WARPS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] resident,
  input  logic [NUM_WARPS-1:0] arrive,
  input  logic [NUM_WARPS-1:0] exit_w,
  input  logic                 clear,
  output logic [NUM_WARPS-1:0] arrived_o,
  output logic [NUM_WARPS-1:0] exited_o,
  output logic                 complete_o
);
  logic [NUM_WARPS-1:0] arr_in, ex_in, present, waiting;

  // exit wins over a same-cycle arrival; a warp that has exited cannot arrive
  assign arr_in  = arrive & resident & ~exited_o & ~exit_w;
  assign ex_in   = exit_w & resident;
  assign present = (arrived_o | arr_in | exited_o | ex_in) & resident;
  assign waiting = (arrived_o | arr_in) & resident;
  assign complete_o = (|resident) && (present == resident) && (|waiting);

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_lane
    logic arr_q, ex_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arr_q <= 1'b0;
        ex_q  <= 1'b0;
      end else begin
        ex_q <= (ex_q | exit_w[i]) & resident[i];
        if (clear || !resident[i] || exit_w[i]) arr_q <= 1'b0;
        else if (arrive[i] && !ex_q)            arr_q <= 1'b1;
      end
    end
    assign arrived_o[i] = arr_q;
    assign exited_o[i]  = ex_q;
  end

  // R2: a stalled warp stays stalled until the release clears it
  a_r2_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((arrived_o & $past(arrived_o & resident & ~exit_w))
               == $past(arrived_o & resident & ~exit_w)));
  // R7: no stall bit for a slot that was not resident
  a_r7_nonresident_idle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((arrived_o & ~$past(resident)) == '0));
  // R6: a warp that has exited never waits
  a_r6_exit_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (arrived_o & exited_o) == '0);
endmodule

// File: rtl/barrier_release_timer.sv
module barrier_release_timer
  import warp_barrier_pkg::*;
#(
  parameter int REL_DELAY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic expire_o,
  output logic done_o
);
  localparam int CW = $clog2(REL_DELAY + 1);

  bar_state_e    state;
  logic [CW-1:0] cnt;

  assign expire_o = (state == BAR_HOLD) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= BAR_OPEN;
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= expire_o;
      case (state)
        BAR_OPEN: if (hit) begin
          state <= BAR_HOLD;
          cnt   <= CW'(REL_DELAY - 1);
        end
        BAR_HOLD: if (cnt == '0) state <= BAR_OPEN;
                  else           cnt   <= cnt - 1'b1;
        default:  state <= BAR_OPEN;
      endcase
    end
  end

  // R3: release is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3: a running countdown is never cut short
  a_r3_hold_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BAR_HOLD && cnt != '0) |=> (state == BAR_HOLD && !done_o));
endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
  parameter int NUM_WARPS = 16,
  parameter int REL_DELAY = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_resident_i,
  input  logic [NUM_WARPS-1:0] warp_arrive_i,
  input  logic [NUM_WARPS-1:0] warp_exit_i,
  output logic [NUM_WARPS-1:0] warp_stall_o,
  output logic                 bar_done_o
);
  logic [NUM_WARPS-1:0] arrived, exited;
  logic                 complete, expire;

  warp_flag_bank #(.NUM_WARPS(NUM_WARPS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .resident(warp_resident_i), .arrive(warp_arrive_i), .exit_w(warp_exit_i),
    .clear(expire),
    .arrived_o(arrived), .exited_o(exited), .complete_o(complete)
  );

  barrier_release_timer #(.REL_DELAY(REL_DELAY)) u_timer (
    .clk(clk), .rst_n(rst_n), .hit(complete),
    .expire_o(expire), .done_o(bar_done_o)
  );

  assign warp_stall_o = arrived;

  // R3: release frees every warp in the same cycle
  a_r3_release_frees_all: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done_o |-> (warp_stall_o == '0));
  // R9: a release needs at least one warp that was waiting
  a_r9_release_needs_waiter: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done_o |-> $past(|warp_stall_o));
  // R6: exited slots are only those still resident
  a_r6_exit_resident: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((exited & ~$past(warp_resident_i)) == '0));
endmodule

// File: tb/sim_warp_barrier.sv
`timescale 1ns/100ps
module sim_warp_barrier;
  localparam int N = 16;
  localparam int D = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] resident = '0, arrive = '0, exit_w = '0;
  logic [N-1:0] stall;
  logic         done;
  int           checks = 0, errors = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  warp_barrier #(.NUM_WARPS(N), .REL_DELAY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .warp_resident_i(resident),
    .warp_arrive_i(arrive), .warp_exit_i(exit_w),
    .warp_stall_o(stall), .bar_done_o(done)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [N-1:0] exp_stall,
                           input logic exp_done);
    chk(stall == exp_stall && done == exp_done, req, "{stall,done}",
        {15'd0, stall, done}, {15'd0, exp_stall, exp_done});
  endtask

  task automatic pulse(input logic [N-1:0] a, input logic [N-1:0] e);
    arrive = a; exit_w = e;
    tick();
    arrive = '0; exit_w = '0;
  endtask

  // called in the cycle right after the completing event was sampled
  task automatic wait_release(input logic [N-1:0] exp_stall, input string req);
    for (int j = 0; j < D; j++) begin
      chk_state(req, exp_stall, 1'b0);
      tick();
    end
    chk_state(req, '0, 1'b1);
    tick();
    chk_state(req, '0, 1'b0);
  endtask

  task automatic new_block(input logic [N-1:0] res);
    resident = '0; tick();
    resident = res; tick();
  endtask

  initial begin
    logic [N-1:0] res, acc, a, e;
    int tm [N];
    bit ex [N];
    int tlast;
    void'($urandom(32'd1234));
    repeat (4) tick();
    chk_state("R1", '0, 1'b0);
    rst_n = 1'b1;
    tick();
    chk_state("R1", '0, 1'b0);

    // R2/R3: four warps arrive one after another
    new_block(16'h000F);
    pulse(16'h0003, '0); chk_state("R2", 16'h0003, 1'b0);
    pulse(16'h0004, '0); chk_state("R2", 16'h0007, 1'b0);
    pulse(16'h0008, '0);
    wait_release(16'h000F, "R3");

    // R4/R5: repeat arrival while stalled is ignored, next instance pairs anew
    new_block(16'h0003);
    pulse(16'h0001, '0); chk_state("R4", 16'h0001, 1'b0);
    pulse(16'h0001, '0); chk_state("R4", 16'h0001, 1'b0);
    pulse(16'h0002, '0);
    wait_release(16'h0003, "R3");
    pulse(16'h0002, '0);
    repeat (3 * D) tick();
    chk_state("R4", 16'h0002, 1'b0);
    pulse(16'h0001, '0);
    wait_release(16'h0003, "R5");

    // R6: exits count now and later, an exit completes the barrier
    new_block(16'h0007);
    pulse(16'h0001, 16'h0002); chk_state("R6", 16'h0001, 1'b0);
    pulse('0, 16'h0004);
    wait_release(16'h0001, "R6");
    pulse(16'h0001, '0);
    wait_release(16'h0001, "R6");
    // R9: everyone exited, nobody arrived
    pulse('0, 16'h0001);
    repeat (2 * D) begin chk_state("R9", '0, 1'b0); tick(); end

    // R7: non-resident warps ignored
    new_block(16'h0011);
    pulse(16'h0002, '0); chk_state("R7", '0, 1'b0);
    pulse(16'h0001, '0); chk_state("R7", 16'h0001, 1'b0);
    pulse(16'h0010, '0);
    wait_release(16'h0011, "R7");

    // R8: no timeout
    new_block(16'h0003);
    pulse(16'h0001, '0);
    repeat (1000) tick();
    chk_state("R8", 16'h0001, 1'b0);
    pulse('0, 16'h0002);
    wait_release(16'h0001, "R8");

    // R10: single warp back to back
    new_block(16'h0001);
    for (int k = 0; k < 3; k++) begin
      pulse(16'h0001, '0);
      wait_release(16'h0001, "R10");
    end

    // random rounds, expected values from the requirements
    for (int r = 0; r < 60; r++) begin
      res = N'($urandom);
      if (res == '0) res = 16'h0001;
      new_block(res);
      tlast = 0;
      for (int i = 0; i < N; i++) begin
        tm[i] = $urandom % 6;
        ex[i] = ($urandom % 3) == 0;
        if (res[i] && tm[i] > tlast) tlast = tm[i];
      end
      begin
        bit any_arr = 0;
        for (int i = 0; i < N; i++) if (res[i] && !ex[i]) any_arr = 1;
        if (!any_arr)
          for (int i = 0; i < N; i++) if (res[i]) begin ex[i] = 0; break; end
      end
      acc = '0;
      for (int t = 0; t <= tlast; t++) begin
        a = '0; e = '0;
        for (int i = 0; i < N; i++)
          if (res[i] && tm[i] == t) begin
            if (ex[i]) e[i] = 1'b1; else a[i] = 1'b1;
          end
        a |= N'($urandom) & ~res;          // R7 noise
        if ($urandom % 2) a |= acc;        // R4 repeat arrivals
        arrive = a; exit_w = e;
        tick();
        arrive = '0; exit_w = '0;
        acc |= a & res;
        if (t < tlast) chk_state("R3", acc, 1'b0);
      end
      wait_release(acc, "R3");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule